// File: doc/BRIEF.md
# Serial EEPROM Slave Emulator

This block sits on an SPI bus as a slave and answers like a small serial EEPROM. Its storage is a byte array held in flip-flops. A host can set and clear a write-enable latch, read and write a status byte, stream bytes out from any address, and load up to one page of bytes in a single frame. Page data is gathered in a buffer. When chip select is released, a program timer starts. During that time the block reports busy, and at the end the buffered bytes are copied into the array, except for bytes that fall inside the range guarded by the protect field of the status byte.

The SPI pins run in mode 0. MOSI is taken on the rising SCK edge and MISO changes after the falling edge. The pins are oversampled by the system clock through two-stage synchronizers. Parameters set the number of address bytes (1 to 3), the memory size, the page size and the program time in clock cycles.

Top module: `spi_eeprom_emu`

## Requirements
- R1: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Opcode 0x05 returns the status byte, repeated for as long as the frame lasts. Status layout: bit 0 busy, bit 1 write-enable latch, bits 3:2 protect field, bit 7 write-protect enable, bits 6:4 read as 0.
- R2: Opcodes 0x03 and 0x02 are followed by ADDR_BYTES address bytes, most significant first. Only the low log2(MEM_BYTES) address bits are used.
- R3: A read (0x03) returns the addressed byte MSB first, and its first bit is valid before the first SCK rise after the address. Further bytes follow from incrementing addresses while chip select stays low, wrapping from the last byte to address 0. SCK high and low phases must each last at least 8 clock cycles.
- R4: A write (0x02) or status write (0x01) issued while the latch is clear is ignored: no busy period, and memory and status stay unchanged.
- R5: Write data bytes fill consecutive offsets within the addressed page. Past the page end they wrap to the start of the same page and never reach the next page.
- R6: After an accepted write frame ends, busy reads 1 for exactly PROG_CYCLES clock cycles. When busy clears, the new data is in memory and the latch is clear.
- R7: While busy, only opcode 0x05 is served. Every other opcode (read, write, latch set or clear) has no effect, and MISO stays low for the rest of that frame.
- R8: A write or status write is committed only if chip select rises after a whole number of bytes and at least one data byte was received. Otherwise nothing changes and the latch stays set.
- R9: Protect field 01 guards the top quarter of memory, 10 the top half and 11 all of it. Write bytes aimed at guarded addresses are dropped, while the rest of the page is written.
- R10: A status write with the latch set loads bits 7 and 3:2 from its data byte at the end of a PROG_CYCLES busy period. The other bits are not writable.
- R11: After reset, status reads 0x00, every memory byte reads 0xFF and MISO is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for oversampling and all state |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the bus master, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, low when deselected |

## Verification
Received bits reach the command logic about four clock cycles after the SCK edge that carries them. A reply byte is loaded about three cycles after that and is on MISO well before the next rising SCK. The bench therefore holds each SCK phase for ten clock cycles and samples MISO on the falling clock edge just before it raises SCK. Busy rises two to three cycles after chip select goes high, so the status poll issued directly after a write frame must see it set. The memory commit lands one cycle after busy clears, which is well before any later read frame can reach its data phase. The bench therefore reads data back only after a poll has shown busy clear, and the bound checker counts the busy cycles exactly.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    localparam logic [7:0] OPC_WRSR  = 8'h01;
    localparam logic [7:0] OPC_WRITE = 8'h02;
    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_WRDI  = 8'h04;
    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_WREN  = 8'h06;

    typedef enum logic [2:0] {
        CS_OPCODE,
        CS_ADDR,
        CS_WDATA,
        CS_RDATA,
        CS_STAT,
        CS_SRDATA,
        CS_SRDONE,
        CS_SKIP
    } cmd_state_e;

    typedef enum logic {
        PEND_DATA,
        PEND_STAT
    } pend_e;

    typedef struct packed {
        logic       wpen;
        logic [1:0] bp;
    } prot_cfg_t;

    // guard decision from the protect field and the two top address bits
    function automatic logic is_protected(input logic [1:0] bp, input logic top1, input logic top0);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return top1 & top0;
            2'b10:   return top1;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] pack_status(input logic busy, input logic wel, input prot_cfg_t c);
        return {c.wpen, 3'b000, c.bp, wel, busy};
    endfunction

endpackage

// File: rtl/spi_ee_link.sv
module spi_ee_link (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck_pin,
    input  logic       csn_pin,
    input  logic       mosi_pin,
    output logic       miso_pin,
    output logic       cs_act,
    output logic       cs_end,
    output logic       on_boundary,
    output logic       byte_stb,
    output logic [7:0] rx_byte,
    input  logic       tx_load,
    input  logic [7:0] tx_byte
);
    logic [2:0] sck_q;
    logic [2:0] csn_q;
    logic [1:0] mosi_q;
    logic       sck_rise;
    logic       sck_fall;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sr;
    logic [7:0] tx_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q  <= '0;
            csn_q  <= '1;
            mosi_q <= '0;
        end else begin
            sck_q  <= {sck_q[1:0], sck_pin};
            csn_q  <= {csn_q[1:0], csn_pin};
            mosi_q <= {mosi_q[0], mosi_pin};
        end
    end

    assign sck_rise    = sck_q[1] & ~sck_q[2];
    assign sck_fall    = ~sck_q[1] & sck_q[2];
    assign cs_act      = ~csn_q[1];
    assign cs_end      = csn_q[1] & ~csn_q[2];
    assign on_boundary = (bit_cnt == 3'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            byte_stb <= 1'b0;
            rx_byte  <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (!cs_act) begin
                bit_cnt <= '0;
                tx_sr   <= '0;
            end else begin
                if (sck_rise) begin
                    rx_sr   <= {rx_sr[5:0], mosi_q[1]};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        byte_stb <= 1'b1;
                        rx_byte  <= {rx_sr, mosi_q[1]};
                    end
                end
                // a new byte is presented whole; shifting only happens mid-byte
                if (tx_load) begin
                    tx_sr <= tx_byte;
                end else if (sck_fall && bit_cnt != 3'd0) begin
                    tx_sr <= {tx_sr[6:0], 1'b0};
                end
            end
        end
    end

    assign miso_pin = cs_act & tx_sr[7];

endmodule

// File: rtl/spi_ee_store.sv
module spi_ee_store
    import spi_ee_pkg::*;
#(
    parameter int MEM_BYTES  = 256,
    parameter int PAGE_BYTES = 16,
    parameter int AW         = 8,
    parameter int PW         = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    rd_addr,
    output logic [7:0]       rd_data,
    input  logic             buf_clear,
    input  logic             buf_we,
    input  logic [PW-1:0]    buf_off,
    input  logic [7:0]       buf_data,
    input  logic             commit,
    input  logic [AW-PW-1:0] page_sel,
    input  logic [1:0]       bp
);
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pmask;
    logic [7:0]            cells [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            pmask <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'h00;
        end else if (buf_clear) begin
            pmask <= '0;
        end else if (buf_we) begin
            pbuf[buf_off]  <= buf_data;
            pmask[buf_off] <= 1'b1;
        end
    end

    for (genvar g = 0; g < MEM_BYTES; g++) begin : g_cell
        localparam logic [AW-1:0] CA = AW'(g);
        logic [7:0] val;
        logic       hit;
        assign hit = commit && (page_sel == CA[AW-1:PW]) && pmask[CA[PW-1:0]]
                     && !is_protected(bp, CA[AW-1], CA[AW-2]);
        always_ff @(posedge clk) begin
            if (rst)      val <= 8'hFF;
            else if (hit) val <= pbuf[CA[PW-1:0]];
        end
        assign cells[g] = val;
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/spi_ee_cmd.sv
module spi_ee_cmd
    import spi_ee_pkg::*;
#(
    parameter int ADDR_BYTES  = 2,
    parameter int AW          = 8,
    parameter int PW          = 4,
    parameter int PROG_CYCLES = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_act,
    input  logic             cs_end,
    input  logic             on_boundary,
    input  logic             byte_stb,
    input  logic [7:0]       rx_byte,
    output logic             tx_load,
    output logic [7:0]       tx_byte,
    output logic [AW-1:0]    rd_addr,
    input  logic [7:0]       rd_data,
    output logic             buf_clear,
    output logic             buf_we,
    output logic [PW-1:0]    buf_off,
    output logic [7:0]       buf_data,
    output logic             commit,
    output logic [AW-PW-1:0] page_sel,
    output prot_cfg_t        prot,
    output logic             busy,
    output logic             wel
);
    localparam int         TW    = $clog2(PROG_CYCLES + 1);
    localparam logic [1:0] ALAST = 2'(ADDR_BYTES - 1);

    cmd_state_e    st;
    logic [1:0]    acnt;
    logic [23:0]   addr_sr;
    logic [23:0]   addr_next;
    logic          is_rd;
    logic [PW-1:0] woff;
    logic          have_data;
    logic          load_pend;
    pend_e         pend_kind;
    prot_cfg_t     sr_new;
    logic [TW-1:0] timer;

    assign addr_next = {addr_sr[15:0], rx_byte};

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= CS_OPCODE;
            acnt      <= '0;
            addr_sr   <= '0;
            is_rd     <= 1'b0;
            woff      <= '0;
            have_data <= 1'b0;
            load_pend <= 1'b0;
            pend_kind <= PEND_DATA;
            sr_new    <= '0;
            timer     <= '0;
            busy      <= 1'b0;
            wel       <= 1'b0;
            prot      <= '0;
            rd_addr   <= '0;
            page_sel  <= '0;
            tx_load   <= 1'b0;
            tx_byte   <= '0;
            buf_clear <= 1'b0;
            buf_we    <= 1'b0;
            buf_off   <= '0;
            buf_data  <= '0;
            commit    <= 1'b0;
        end else begin
            tx_load   <= 1'b0;
            buf_clear <= 1'b0;
            buf_we    <= 1'b0;
            commit    <= 1'b0;

            // program timer: the update lands when it runs out
            if (busy) begin
                if (timer == '0) begin
                    busy <= 1'b0;
                    wel  <= 1'b0;
                    if (pend_kind == PEND_STAT) prot <= sr_new;
                    else                        commit <= 1'b1;
                end else begin
                    timer <= timer - 1'b1;
                end
            end

            if (!cs_act) begin
                st        <= CS_OPCODE;
                load_pend <= 1'b0;
                if (cs_end && on_boundary && !busy) begin
                    if (st == CS_WDATA && have_data) begin
                        busy      <= 1'b1;
                        timer     <= TW'(PROG_CYCLES - 1);
                        pend_kind <= PEND_DATA;
                    end else if (st == CS_SRDONE) begin
                        busy      <= 1'b1;
                        timer     <= TW'(PROG_CYCLES - 1);
                        pend_kind <= PEND_STAT;
                    end
                end
            end else begin
                if (load_pend) begin
                    load_pend <= 1'b0;
                    tx_load   <= 1'b1;
                    if (st == CS_RDATA) begin
                        tx_byte <= rd_data;
                        rd_addr <= rd_addr + 1'b1;
                    end else begin
                        tx_byte <= pack_status(busy, wel, prot);
                    end
                end
                if (byte_stb) begin
                    case (st)
                        CS_OPCODE: begin
                            if (busy) begin
                                st        <= (rx_byte == OPC_RDSR) ? CS_STAT : CS_SKIP;
                                load_pend <= (rx_byte == OPC_RDSR);
                            end else begin
                                acnt <= '0;
                                case (rx_byte)
                                    OPC_WREN: begin wel <= 1'b1; st <= CS_SKIP; end
                                    OPC_WRDI: begin wel <= 1'b0; st <= CS_SKIP; end
                                    OPC_RDSR: begin st <= CS_STAT; load_pend <= 1'b1; end
                                    OPC_WRSR: st <= wel ? CS_SRDATA : CS_SKIP;
                                    OPC_READ: begin st <= CS_ADDR; is_rd <= 1'b1; end
                                    OPC_WRITE: begin
                                        st    <= wel ? CS_ADDR : CS_SKIP;
                                        is_rd <= 1'b0;
                                    end
                                    default: st <= CS_SKIP;
                                endcase
                            end
                        end
                        CS_ADDR: begin
                            addr_sr <= addr_next;
                            acnt    <= acnt + 2'd1;
                            if (acnt == ALAST) begin
                                if (is_rd) begin
                                    rd_addr   <= addr_next[AW-1:0];
                                    st        <= CS_RDATA;
                                    load_pend <= 1'b1;
                                end else begin
                                    woff      <= addr_next[PW-1:0];
                                    page_sel  <= addr_next[AW-1:PW];
                                    buf_clear <= 1'b1;
                                    have_data <= 1'b0;
                                    st        <= CS_WDATA;
                                end
                            end
                        end
                        CS_WDATA: begin
                            buf_we    <= 1'b1;
                            buf_off   <= woff;
                            buf_data  <= rx_byte;
                            woff      <= woff + 1'b1;
                            have_data <= 1'b1;
                        end
                        CS_RDATA, CS_STAT: load_pend <= 1'b1;
                        CS_SRDATA: begin
                            sr_new.wpen <= rx_byte[7];
                            sr_new.bp   <= rx_byte[3:2];
                            st          <= CS_SRDONE;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/spi_eeprom_emu.sv
module spi_eeprom_emu
    import spi_ee_pkg::*;
#(
    parameter int ADDR_BYTES  = 2,
    parameter int MEM_BYTES   = 256,
    parameter int PAGE_BYTES  = 16,
    parameter int PROG_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);

    logic             cs_act;
    logic             cs_end;
    logic             on_boundary;
    logic             byte_stb;
    logic [7:0]       rx_byte;
    logic             tx_load;
    logic [7:0]       tx_byte;
    logic [AW-1:0]    rd_addr;
    logic [7:0]       rd_data;
    logic             buf_clear;
    logic             buf_we;
    logic [PW-1:0]    buf_off;
    logic [7:0]       buf_data;
    logic             commit;
    logic [AW-PW-1:0] page_sel;
    prot_cfg_t        prot;
    logic             busy;
    logic             wel;
    logic [1:0]       bp_w;

    assign bp_w = prot.bp;

    spi_ee_link u_link (
        .clk         (clk),
        .rst         (rst),
        .sck_pin     (spi_sck),
        .csn_pin     (spi_cs_n),
        .mosi_pin    (spi_mosi),
        .miso_pin    (spi_miso),
        .cs_act      (cs_act),
        .cs_end      (cs_end),
        .on_boundary (on_boundary),
        .byte_stb    (byte_stb),
        .rx_byte     (rx_byte),
        .tx_load     (tx_load),
        .tx_byte     (tx_byte)
    );

    spi_ee_cmd #(
        .ADDR_BYTES  (ADDR_BYTES),
        .AW          (AW),
        .PW          (PW),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_cmd (
        .clk         (clk),
        .rst         (rst),
        .cs_act      (cs_act),
        .cs_end      (cs_end),
        .on_boundary (on_boundary),
        .byte_stb    (byte_stb),
        .rx_byte     (rx_byte),
        .tx_load     (tx_load),
        .tx_byte     (tx_byte),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .buf_clear   (buf_clear),
        .buf_we      (buf_we),
        .buf_off     (buf_off),
        .buf_data    (buf_data),
        .commit      (commit),
        .page_sel    (page_sel),
        .prot        (prot),
        .busy        (busy),
        .wel         (wel)
    );

    spi_ee_store #(
        .MEM_BYTES  (MEM_BYTES),
        .PAGE_BYTES (PAGE_BYTES),
        .AW         (AW),
        .PW         (PW)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .buf_clear (buf_clear),
        .buf_we    (buf_we),
        .buf_off   (buf_off),
        .buf_data  (buf_data),
        .commit    (commit),
        .page_sel  (page_sel),
        .bp        (bp_w)
    );

endmodule

// File: rtl/spi_eeprom_emu_chk.sv
module spi_eeprom_emu_chk #(
    parameter int PROG_CYCLES = 250000
) (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       wel,
    input logic [1:0] bp,
    input logic       tx_load,
    input logic       on_boundary
);
    logic [31:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst)       busy_run <= '0;
        else if (busy) busy_run <= busy_run + 32'd1;
        else           busy_run <= '0;
    end

    // R6: busy lasts exactly the program time
    a_r6_busy_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run == 32'(PROG_CYCLES)));

    // R6: latch is clear once programming ends
    a_r6_wel_cleared: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel);

    // R4: programming only starts with the latch set
    a_r4_busy_needs_wel: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wel));

    // R8: programming only starts after a whole number of bits per byte
    a_r8_whole_bytes: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(on_boundary));

    // R10: protect field does not move during a busy period
    a_r10_prot_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(bp));

    // R3: reply bytes are loaded only between bytes
    a_r3_load_on_boundary: assert property (@(posedge clk) disable iff (rst)
        tx_load |-> on_boundary);

endmodule

bind spi_eeprom_emu spi_eeprom_emu_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .wel         (wel),
    .bp          (bp_w),
    .tx_load     (tx_load),
    .on_boundary (on_boundary)
);

// File: tb/spi_eeprom_emu_test.sv
module spi_eeprom_emu_test;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 10;
    localparam int PROG       = 3000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_eeprom_emu #(
        .ADDR_BYTES  (2),
        .MEM_BYTES   (256),
        .PAGE_BYTES  (16),
        .PROG_CYCLES (PROG)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .spi_sck  (sck),
        .spi_cs_n (cs_n),
        .spi_mosi (mosi),
        .spi_miso (miso)
    );

    // {address, data} pairs written one at a time and read back
    localparam logic [15:0] VEC [8] = '{16'h005A, 16'hFF77, 16'h103C, 16'h47A5,
                                        16'h810F, 16'h9EE1, 16'hC396, 16'h6B00};

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            idle(HP);
            rx[i] = miso;
            sck = 1'b1;
            idle(HP);
            sck = 1'b0;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        idle(HP);
    endtask

    task automatic desel();
        idle(HP);
        cs_n = 1'b1;
        idle(2*HP);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        sel(); xfer(op, d); desel();
    endtask

    task automatic rd_status(output logic [7:0] s);
        logic [7:0] d;
        sel(); xfer(8'h05, d); xfer(8'h00, s); desel();
    endtask

    task automatic wr_status(input logic [7:0] v);
        logic [7:0] d;
        sel(); xfer(8'h01, d); xfer(v, d); desel();
    endtask

    task automatic wr_n(input logic [15:0] a, input logic [31:0] data, input int n);
        logic [7:0] d;
        sel();
        xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d);
        for (int k = 0; k < n; k++) xfer(data[31-8*k -: 8], d);
        desel();
    endtask

    task automatic rd_n(input logic [15:0] a, input int n, output logic [31:0] q);
        logic [7:0] d;
        q = '0;
        sel();
        xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, d);
            q = {q[23:0], d};
        end
        desel();
    endtask

    task automatic wait_ready();
        logic [7:0] s;
        for (int k = 0; k < 40; k++) begin
            rd_status(s);
            if (!s[0]) return;
        end
        check("R6 busy never cleared", 32'(s[0]), 32'h0);
    endtask

    initial begin
        logic [7:0]  s;
        logic [31:0] q;
        logic [7:0]  d;
        idle(5);
        rst = 1'b0;
        idle(5);

        // R11: reset state
        check("R11 miso idle", 32'(miso), 32'h0);
        rd_status(s);
        check("R11 status", 32'(s), 32'h00);
        rd_n(16'h0010, 1, q);
        check("R11 memory erased", q, 32'hFF);

        // R1: latch set and clear
        cmd1(8'h06);
        rd_status(s);
        check("R1 latch set", 32'(s), 32'h02);
        cmd1(8'h04);
        rd_status(s);
        check("R1 latch clear", 32'(s), 32'h00);

        // R4: write without the latch
        wr_n(16'h0040, 32'h11000000, 1);
        rd_status(s);
        check("R4 no busy", 32'(s), 32'h00);
        rd_n(16'h0040, 1, q);
        check("R4 memory kept", q, 32'hFF);

        // R6: table of single-byte writes
        for (int v = 0; v < 8; v++) begin
            cmd1(8'h06);
            wr_n({8'h00, VEC[v][15:8]}, {VEC[v][7:0], 24'h0}, 1);
            wait_ready();
            rd_n({8'h00, VEC[v][15:8]}, 1, q);
            check("R6 table readback", q, 32'(VEC[v][7:0]));
        end

        // R3: streaming with wrap to address 0, and multi-byte stream
        rd_n(16'h00FF, 2, q);
        check("R3 wrap read", q, 32'h775A);
        cmd1(8'h06);
        wr_n(16'h0020, 32'h01020304, 4);
        wait_ready();
        rd_n(16'h0020, 4, q);
        check("R3 stream read", q, 32'h01020304);

        // R2: address byte order
        cmd1(8'h06);
        wr_n(16'h00A5, 32'h5C000000, 1);
        wait_ready();
        rd_n(16'h00A5, 1, q);
        check("R2 msb first", q, 32'h5C);
        rd_n(16'hA500, 1, q);
        check("R2 swapped order hits 0x00", q, 32'h5A);

        // R5: in-page wrap
        cmd1(8'h06);
        wr_n(16'h003E, 32'hAABBCCDD, 4);
        wait_ready();
        rd_n(16'h003E, 2, q);
        check("R5 page tail", q, 32'hAABB);
        rd_n(16'h0030, 2, q);
        check("R5 page head", q, 32'hCCDD);
        rd_n(16'h0040, 1, q);
        check("R5 next page untouched", q, 32'hFF);

        // R6/R7: behaviour while busy
        cmd1(8'h06);
        wr_n(16'h0050, 32'h99000000, 1);
        rd_status(s);
        check("R6 busy after frame", 32'(s), 32'h03);
        rd_n(16'h0050, 1, q);
        check("R7 read ignored while busy", q, 32'h00);
        cmd1(8'h04);
        rd_status(s);
        check("R7 latch clear ignored while busy", 32'(s), 32'h03);
        wait_ready();
        rd_status(s);
        check("R6 latch cleared at end", 32'(s), 32'h00);
        rd_n(16'h0050, 1, q);
        check("R6 data committed", q, 32'h99);

        // R8: frame ends mid-byte
        cmd1(8'h06);
        sel();
        xfer(8'h02, d); xfer(8'h00, d); xfer(8'h60, d); xfer(8'h55, d);
        for (int i = 0; i < 3; i++) begin
            mosi = 1'b1; idle(HP); sck = 1'b1; idle(HP); sck = 1'b0;
        end
        desel();
        rd_status(s);
        check("R8 no busy, latch kept", 32'(s), 32'h02);
        rd_n(16'h0060, 1, q);
        check("R8 memory kept", q, 32'hFF);
        cmd1(8'h04);

        // R10: status write
        cmd1(8'h06);
        wr_status(8'hF4);
        rd_status(s);
        check("R10 busy during status write", 32'(s), 32'h03);
        wait_ready();
        rd_status(s);
        check("R10 writable bits only", 32'(s), 32'h84);
        wr_status(8'h00);
        rd_status(s);
        check("R10 ignored without latch", 32'(s), 32'h84);

        // R9: top quarter guarded
        cmd1(8'h06);
        wr_n(16'h00C5, 32'h12000000, 1);
        wait_ready();
        rd_n(16'h00C5, 1, q);
        check("R9 guarded byte dropped", q, 32'hFF);
        cmd1(8'h06);
        wr_n(16'h00B5, 32'h34000000, 1);
        wait_ready();
        rd_n(16'h00B5, 1, q);
        check("R9 unguarded byte written", q, 32'h34);

        // R9: whole array guarded
        cmd1(8'h06);
        wr_status(8'h0C);
        wait_ready();
        rd_status(s);
        check("R10 protect all", 32'(s), 32'h0C);
        cmd1(8'h06);
        wr_n(16'h0005, 32'h66000000, 1);
        wait_ready();
        rd_n(16'h0005, 1, q);
        check("R9 all guarded", q, 32'hFF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule